// File: doc/BRIEF.md
# PCI Configuration Base Address Register Bank

This block holds the six base address registers of a PCI function's configuration header. Configuration software reaches them through a simple port: a byte offset, a write enable, 32 bits of write data and a registered 32-bit read result. The bank answers the usual sizing probe, in which software writes all ones and reads back a mask that shows how large the window is. It keeps the read-only type bits of each register intact, and it tells I/O-space registers apart from memory-space registers by bit 0 of the stored value.

For every register the bank drives a decoded system address. This is the programmed base plus a fixed window base, where the I/O window and the memory window each have their own base. Whenever that address is reprogrammed, the bank raises a one-cycle range-change pulse so that downstream address decoders can refresh. Any register can be declared at elaboration as a fixed legacy I/O register. Such a register takes its decoded address from a preset at reset, reads back as zero and ignores software. Sizes are parameters. A non-legacy register with a nonzero size that is not a power of two stops elaboration with an error.

Top module: `cfgBarBank`

## Requirements
- R1: After reset each non-legacy register reads back its preset value (holding its type bits) and drives a decoded address of zero. No range-change pulse is high.
- R2: Writing 0xFFFFFFFF to a non-legacy register stores the complement of (size − 1), with the type-mask bits kept from the old value. The decoded address does not change and no pulse is raised.
- R3: The type mask is 0x3 when bit 0 of the stored value is 1 (I/O space) and 0xF when it is 0 (memory space; bits 3:1 are type and prefetchable). On a write, the stored value becomes the new data outside the mask ORed with the old value inside the mask.
- R4: A non-sizing write whose data is nonzero after masking sets the decoded address to the masked data plus the I/O window base (I/O register) or the memory window base (memory register). It raises that register's range-change pulse for exactly the one cycle after the write edge.
- R5: A non-sizing write whose data is zero after masking leaves the decoded address unchanged and raises no pulse. The stored value still follows R3.
- R6: A legacy register drives, from reset on, its preset value plus the I/O window base. It reads back as zero, ignores every write and never pulses.
- R7: Register n sits at byte offset 0x10 + 4·n for n = 0..5. A write to any other offset, including an unaligned one, changes nothing, and a read there returns zero.
- R8: The read result for an offset presented in one cycle appears after the next clock edge. It reflects every write completed by that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgOffset | input | 8 | Configuration byte offset for read and write |
| cfgWrEn | input | 1 | Write strobe for the current cycle |
| cfgWrData | input | 32 | Write data |
| cfgRdData | output | 32 | Registered read data for the previous cycle's offset |
| barBase | output | 6×40 | Decoded address of register n in bits [40n+39:40n] |
| rangeChange | output | 6 | One-cycle pulse per register when its decoded address is reprogrammed |

## Verification
The hardest state to reach is an I/O register being reprogrammed with data whose low two bits are set. The result must keep bit 0 and drop bit 1, while data that is zero once masked must leave the decoded address alone. Random data rarely hits these cases. The stimulus therefore adds directed writes of small values (0 to 15), all-ones probes and zero to the random mix, and the bench follows each one with a read so that the preserved type bits become visible.

// File: rtl/cfgbar_pkg.sv
package cfgbar_pkg;
  localparam int NBAR = 6;
  localparam int CFG_W = 32;
  localparam int IDX_W = $clog2(NBAR);
  localparam logic [CFG_W-1:0] IO_TYPE_MASK = 32'h0000_0003;
  localparam logic [CFG_W-1:0] MEM_TYPE_MASK = 32'h0000_000F;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NBAR-1:0] storeSel;   // register takes a new stored value
    logic            sizeProbe;  // write data is the all-ones probe
    logic [NBAR-1:0] decodeLoad; // decoded address is reloaded (and pulses)
    logic            rdHit;      // read offset falls on a register
    logic [IDX_W-1:0] rdIdx;
  } barStrobe_t;

  function automatic logic [CFG_W-1:0] typeMask(input logic ioSpace);
    return ioSpace ? IO_TYPE_MASK : MEM_TYPE_MASK;
  endfunction
endpackage

// File: rtl/cfgBarCtrl.sv
module cfgBarCtrl
  import cfgbar_pkg::*;
#(
  parameter int NUM_BARS = NBAR,
  parameter int OFF_W = 8,
  parameter logic [OFF_W-1:0] FIRST_OFF = 8'h10,
  parameter logic [NUM_BARS-1:0] LEGACY_MASK = '0
) (
  input  logic [OFF_W-1:0]    cfgOffset,
  input  logic                cfgWrEn,
  input  logic [CFG_W-1:0]    cfgWrData,
  input  logic [NUM_BARS-1:0] ioSpace,
  output barStrobe_t          strobe
);
  localparam logic [OFF_W-1:0] LAST_OFF = FIRST_OFF + OFF_W'(4 * (NUM_BARS - 1));

  logic [OFF_W-1:0] relOff;
  logic             inRange;
  logic [IDX_W-1:0] barIdx;
  logic             probe;
  logic [NUM_BARS-1:0] hitVec;
  logic [NUM_BARS-1:0] maskedNz;

  always_comb begin
    relOff  = cfgOffset - FIRST_OFF;
    inRange = (cfgOffset >= FIRST_OFF) && (cfgOffset <= LAST_OFF) && (cfgOffset[1:0] == 2'b00);
    barIdx  = relOff[IDX_W+1:2];
    probe   = (cfgWrData == '1);
  end

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_sel
    assign hitVec[i]   = inRange && (barIdx == IDX_W'(i));
    assign maskedNz[i] = |(cfgWrData & ~typeMask(ioSpace[i]));
    assign strobe.storeSel[i]   = cfgWrEn && hitVec[i] && !LEGACY_MASK[i];
    assign strobe.decodeLoad[i] = cfgWrEn && hitVec[i] && !LEGACY_MASK[i] && !probe && maskedNz[i];
  end

  assign strobe.sizeProbe = probe;
  assign strobe.rdHit     = inRange;
  assign strobe.rdIdx     = barIdx;
endmodule

// File: rtl/cfgBarDatapath.sv
module cfgBarDatapath
  import cfgbar_pkg::*;
#(
  parameter int NUM_BARS = NBAR,
  parameter int ADDR_W = 40,
  parameter logic [NUM_BARS*CFG_W-1:0] BAR_SIZE_VEC = '0,
  parameter logic [NUM_BARS*CFG_W-1:0] BAR_PRESET_VEC = '0,
  parameter logic [NUM_BARS-1:0] LEGACY_MASK = '0,
  parameter logic [ADDR_W-1:0] IO_WIN_BASE = '0,
  parameter logic [ADDR_W-1:0] MEM_WIN_BASE = '0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  barStrobe_t                 strobe,
  input  logic [CFG_W-1:0]           cfgWrData,
  output logic [NUM_BARS-1:0]        ioSpace,
  output logic [CFG_W-1:0]           cfgRdData,
  output logic [NUM_BARS*ADDR_W-1:0] barBase,
  output logic [NUM_BARS-1:0]        rangeChange
);
  logic [CFG_W-1:0] storedArr [NUM_BARS];

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
    localparam logic [CFG_W-1:0] SIZE   = BAR_SIZE_VEC[i*CFG_W +: CFG_W];
    localparam logic [CFG_W-1:0] PRESET = BAR_PRESET_VEC[i*CFG_W +: CFG_W];
    localparam logic [ADDR_W-1:0] LEGACY_BASE = IO_WIN_BASE + ADDR_W'(PRESET);

    if (!LEGACY_MASK[i] && SIZE != 0 && (SIZE & (SIZE - 1)) != 0) begin : g_badSize
      $error("register %0d size 0x%0h is not a power of two", i, SIZE);
    end

    logic [CFG_W-1:0]  storedQ;
    logic [ADDR_W-1:0] baseQ;
    logic              pulseQ;
    logic [CFG_W-1:0]  mask;
    logic [CFG_W-1:0]  newRaw;
    logic [CFG_W-1:0]  nextStored;
    logic [ADDR_W-1:0] nextBase;

    always_comb begin
      mask       = typeMask(storedQ[0]);
      newRaw     = strobe.sizeProbe ? ~(SIZE - 1) : cfgWrData;
      nextStored = (newRaw & ~mask) | (storedQ & mask);
      nextBase   = (storedQ[0] ? IO_WIN_BASE : MEM_WIN_BASE) + ADDR_W'(cfgWrData & ~mask);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        storedQ <= LEGACY_MASK[i] ? '0 : PRESET;
        baseQ   <= LEGACY_MASK[i] ? LEGACY_BASE : '0;
        pulseQ  <= 1'b0;
      end else begin
        pulseQ <= strobe.decodeLoad[i];
        if (strobe.storeSel[i]) storedQ <= nextStored;
        if (strobe.decodeLoad[i]) baseQ <= nextBase;
      end
    end

    assign storedArr[i] = storedQ;
    assign ioSpace[i]   = storedQ[0];
    assign barBase[i*ADDR_W +: ADDR_W] = baseQ;
    assign rangeChange[i] = pulseQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) cfgRdData <= '0;
    else if (strobe.rdHit && (int'(strobe.rdIdx) < NUM_BARS)) cfgRdData <= storedArr[strobe.rdIdx];
    else cfgRdData <= '0;
  end
endmodule

// File: rtl/cfgBarBank.sv
module cfgBarBank
  import cfgbar_pkg::*;
#(
  parameter int NUM_BARS = NBAR,
  parameter int ADDR_W = 40,
  parameter int OFF_W = 8,
  parameter logic [NUM_BARS*CFG_W-1:0] BAR_SIZE_VEC =
    {32'h0, 32'h0, 32'h0, 32'h1000, 32'h20, 32'h100},
  parameter logic [NUM_BARS*CFG_W-1:0] BAR_PRESET_VEC =
    {32'h3F6, 32'h0, 32'h1F0, 32'h8, 32'h1, 32'h0},
  parameter logic [NUM_BARS-1:0] LEGACY_MASK = 6'b101000,
  parameter logic [ADDR_W-1:0] IO_WIN_BASE = 40'h10_0000_0000,
  parameter logic [ADDR_W-1:0] MEM_WIN_BASE = 40'h20_0000_0000
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [OFF_W-1:0]           cfgOffset,
  input  logic                       cfgWrEn,
  input  logic [CFG_W-1:0]           cfgWrData,
  output logic [CFG_W-1:0]           cfgRdData,
  output logic [NUM_BARS*ADDR_W-1:0] barBase,
  output logic [NUM_BARS-1:0]        rangeChange
);
  if (NUM_BARS != NBAR) begin : g_cntCheck
    $error("NUM_BARS must equal the package register count");
  end

  barStrobe_t          strobe;
  logic [NUM_BARS-1:0] ioSpace;

  cfgBarCtrl #(
    .NUM_BARS(NUM_BARS), .OFF_W(OFF_W), .FIRST_OFF(OFF_W'(8'h10)), .LEGACY_MASK(LEGACY_MASK)
  ) ctrl_i (
    .cfgOffset(cfgOffset), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .ioSpace(ioSpace), .strobe(strobe)
  );

  cfgBarDatapath #(
    .NUM_BARS(NUM_BARS), .ADDR_W(ADDR_W), .BAR_SIZE_VEC(BAR_SIZE_VEC),
    .BAR_PRESET_VEC(BAR_PRESET_VEC), .LEGACY_MASK(LEGACY_MASK),
    .IO_WIN_BASE(IO_WIN_BASE), .MEM_WIN_BASE(MEM_WIN_BASE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgWrData(cfgWrData),
    .ioSpace(ioSpace), .cfgRdData(cfgRdData), .barBase(barBase),
    .rangeChange(rangeChange)
  );
endmodule

// File: rtl/cfgBarChecker.sv
module cfgBarChecker #(
  parameter int NUM_BARS = 6,
  parameter int ADDR_W = 40,
  parameter int OFF_W = 8,
  parameter logic [NUM_BARS-1:0] LEGACY_MASK = '0
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [OFF_W-1:0]           cfgOffset,
  input logic                       cfgWrEn,
  input logic [31:0]                cfgWrData,
  input logic [NUM_BARS*ADDR_W-1:0] barBase,
  input logic [NUM_BARS-1:0]        rangeChange
);
  // R4: at most one register reprogrammed per write
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rangeChange));

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_chk
    localparam logic [OFF_W-1:0] MY_OFF = OFF_W'(8'h10 + 4 * i);

    // R4 / R2 / R7: a pulse follows a non-probe write to this register's offset
    assert_pulse_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
      rangeChange[i] |-> ($past(cfgWrEn) && ($past(cfgOffset) == MY_OFF) && ($past(cfgWrData) != 32'hFFFF_FFFF)));

    // R5: decoded address only moves together with a pulse
    assert_base_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
      !rangeChange[i] |-> $stable(barBase[i*ADDR_W +: ADDR_W]));

    if (LEGACY_MASK[i]) begin : g_leg
      // R6: fixed registers never pulse
      assert_legacy_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
        !rangeChange[i]);
    end
  end
endmodule

bind cfgBarBank cfgBarChecker #(
  .NUM_BARS(NUM_BARS), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .LEGACY_MASK(LEGACY_MASK)
) chk_i (
  .clk(clk), .rstN(rstN), .cfgOffset(cfgOffset), .cfgWrEn(cfgWrEn),
  .cfgWrData(cfgWrData), .barBase(barBase), .rangeChange(rangeChange)
);

// File: tb/cfgBarBank_tb.sv
module cfgBarBank_tb_top;
  localparam int N = 6;
  localparam int AW = 40;
  localparam logic [N*32-1:0] SIZES   = {32'h0, 32'h0, 32'h0, 32'h1000, 32'h20, 32'h100};
  localparam logic [N*32-1:0] PRESETS = {32'h3F6, 32'h0, 32'h1F0, 32'h8, 32'h1, 32'h0};
  localparam logic [N-1:0] LEG = 6'b101000;
  localparam logic [AW-1:0] IOB = 40'h10_0000_0000;
  localparam logic [AW-1:0] MEMB = 40'h20_0000_0000;

  logic clk = 0, rstN = 0, cfgWrEn = 0;
  logic [7:0] cfgOffset = 0;
  logic [31:0] cfgWrData = 0, cfgRdData;
  logic [N*AW-1:0] barBase;
  logic [N-1:0] rangeChange;

  int total = 0, bad = 0;
  logic [31:0] expStored [N];
  logic [AW-1:0] expBase [N];
  logic [N-1:0] expPulse;

  always #2 clk = ~clk;

  cfgBarBank #(
    .NUM_BARS(N), .ADDR_W(AW), .BAR_SIZE_VEC(SIZES), .BAR_PRESET_VEC(PRESETS),
    .LEGACY_MASK(LEG), .IO_WIN_BASE(IOB), .MEM_WIN_BASE(MEMB)
  ) dut_i (
    .clk(clk), .rstN(rstN), .cfgOffset(cfgOffset), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .barBase(barBase), .rangeChange(rangeChange)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int offIdx(input logic [7:0] off);
    if (off >= 8'h10 && off <= 8'h24 && off[1:0] == 2'b00) return int'((off - 8'h10) >> 2);
    return -1;
  endfunction

  function automatic logic [31:0] tmask(input logic [31:0] v);
    return v[0] ? 32'h3 : 32'hF;
  endfunction

  task automatic checkOutputs(input string req);
    for (int i = 0; i < N; i++)
      chk(barBase[i*AW +: AW] === expBase[i], req, 64'(barBase[i*AW +: AW]), 64'(expBase[i]));
    chk(rangeChange === expPulse, req, 64'(rangeChange), 64'(expPulse));
  endtask

  task automatic doWrite(input logic [7:0] off, input logic [31:0] data, input string req);
    int idx;
    logic [31:0] m, raw;
    @(negedge clk);
    cfgOffset = off; cfgWrData = data; cfgWrEn = 1;
    idx = offIdx(off);
    expPulse = '0;
    if (idx >= 0 && !LEG[idx]) begin
      m = tmask(expStored[idx]);
      raw = (data == 32'hFFFF_FFFF) ? ~(SIZES[idx*32 +: 32] - 32'd1) : data;
      if (data != 32'hFFFF_FFFF && (data & ~m) != 0) begin
        expBase[idx] = (expStored[idx][0] ? IOB : MEMB) + AW'(data & ~m);
        expPulse[idx] = 1'b1;
      end
      expStored[idx] = (raw & ~m) | (expStored[idx] & m);
    end
    @(negedge clk);
    cfgWrEn = 0;
    checkOutputs(req);
    expPulse = '0;
    @(negedge clk);
    checkOutputs({req, " pulse one cycle"});
  endtask

  task automatic doRead(input logic [7:0] off, input string req);
    int idx;
    logic [31:0] e;
    @(negedge clk);
    cfgOffset = off; cfgWrEn = 0;
    idx = offIdx(off);
    e = (idx >= 0) ? expStored[idx] : 32'h0;
    @(negedge clk);
    chk(cfgRdData === e, req, 64'(cfgRdData), 64'(e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin
      expStored[i] = LEG[i] ? 32'h0 : PRESETS[i*32 +: 32];
      expBase[i]   = LEG[i] ? IOB + AW'(PRESETS[i*32 +: 32]) : '0;
    end
    expPulse = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checkOutputs("R1 reset");
    for (int i = 0; i < N; i++) doRead(8'h10 + 8'(4 * i), LEG[i] ? "R6 legacy reads zero" : "R1 preset readback");

    // R2: sizing probes on I/O, memory and zero-size registers
    doWrite(8'h14, 32'hFFFF_FFFF, "R2 probe io");
    doRead(8'h14, "R2 probe io readback");
    doWrite(8'h18, 32'hFFFF_FFFF, "R2 probe mem");
    doRead(8'h18, "R2 probe mem readback");
    doWrite(8'h20, 32'hFFFF_FFFF, "R2 probe zero size");
    doRead(8'h20, "R2 probe zero size readback");
    // R3 / R4: programming keeps type bits
    doWrite(8'h10, 32'h1234_5678, "R4 mem program");
    doRead(8'h10, "R3 mem readback");
    doWrite(8'h18, 32'hABCD_EF07, "R3 prefetch type kept");
    doRead(8'h18, "R3 prefetch readback");
    doWrite(8'h14, 32'h0000_C003, "R4 io program");
    doRead(8'h14, "R3 io readback");
    doWrite(8'h14, 32'h0000_0006, "R4 io small value");
    doRead(8'h14, "R3 io small readback");
    // R5: zero after masking
    doWrite(8'h10, 32'h0000_000F, "R5 masked zero mem");
    doRead(8'h10, "R5 masked zero readback");
    doWrite(8'h14, 32'h0, "R5 zero io");
    // R6: legacy ignored
    doWrite(8'h1C, 32'h5555_5550, "R6 legacy write ignored");
    doRead(8'h1C, "R6 legacy still zero");
    doWrite(8'h24, 32'hFFFF_FFFF, "R6 legacy probe ignored");
    doRead(8'h24, "R6 legacy probe zero");
    // R7: out of range / unaligned
    doWrite(8'h28, 32'h7777_0000, "R7 above range");
    doWrite(8'h0C, 32'h7777_0000, "R7 below range");
    doWrite(8'h11, 32'h7777_0000, "R7 unaligned");
    doRead(8'h28, "R7 read outside");
    doRead(8'h11, "R7 read unaligned");
    // R8: write then immediate read sees the new value one cycle later
    doWrite(8'h10, 32'h0000_0100, "R4 program before latency");
    doRead(8'h10, "R8 read latency");

    for (int k = 0; k < 400; k++) begin
      logic [7:0] off;
      logic [31:0] d;
      int sel;
      sel = $urandom_range(0, 9);
      off = (sel == 9) ? 8'h13 : 8'h08 + 8'(4 * $urandom_range(0, 8));
      case ($urandom_range(0, 5))
        0: d = 32'hFFFF_FFFF;
        1: d = 32'h0;
        2: d = 32'($urandom_range(0, 15));
        default: d = $urandom;
      endcase
      doWrite(off, d, "R4 random write");
      doRead(off, "R8 random readback");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule